// File: doc/BRIEF.md
# Linked-Descriptor Lookup-Table Refill Engine

This block is a bus master that rewrites a rectangular window of a two-dimensional page-address lookup table. Software places a chain of descriptors in memory. Each descriptor names a rectangle of table slots and a run of 32-bit physical addresses. Software then writes the address of the first descriptor into the engine's descriptor register. The engine reads each descriptor through a one-word read port. It then reads the address entries that the descriptor points to and drives each entry onto a table write port, scanning the rectangle row by row. It follows the next pointer of each descriptor until it finds a null one.

Software watches the engine through a small register set. A status word carries a ready flag and an error flag. An interrupt-status byte latches completion and error events, and software clears a bit by writing 1 to it. An enable mask gates these bits onto one interrupt line. Two read-only words report the engine and table counts and the table geometry.

Register accesses use a word index. A write takes effect at the clock edge where `reg_we` is high. Read data is registered and appears in the cycle after `reg_addr` is presented. Memory reads are one-cycle `mem_req` pulses, and each is answered by one `mem_rvalid` pulse some cycles later.

Top module: `lut_refill_engine`

## Requirements
- R1: A descriptor is four words at byte offsets +0, +4, +8 and +12: the next-descriptor address, then the rectangle word, then the control word, then the data pointer. The rectangle word packs x0 in bits [7:0], y0 in [15:8], x1 in [23:16] and y1 in [31:24]. The control word carries the table id in bits [7:4], which is driven on `lut_sel`. The engine walks the chain until it finds a next address of 0.
- R2: A descriptor produces exactly (x1-x0+1)*(y1-y0+1) table writes in row-major order, with x advancing fastest. Entry i is read from the data pointer + 4*i.
- R3: Writing a nonzero value to register index 0 starts a refill at that address. Writing 0 to the same register abandons any refill in progress: no further table writes follow, the status reads ready, and the error flag is cleared.
- R4: In the status register (index 1), bit 0 is ready and bit 1 is error. Ready reads 0 while the engine is fetching or writing. Ready reads 1 once the last entry of the final descriptor has been written.
- R5: The engine raises the error flag and stops the chain if any of these holds: the start address or a next address has bits [3:0] nonzero, the data pointer has bits [3:0] nonzero, x1<x0, or y1<y0. The failing descriptor writes nothing. While the error flag is set, the status reads 2, so error takes precedence over ready.
- R6: In the interrupt-status register (index 2), bit 0 latches chain completion and bit 1 latches an error. Writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged.
- R7: The interrupt enable mask is register index 3. `irq` is the registered OR of the interrupt-status bits ANDed with the mask.
- R8: Index 4 reads the engine count in bits [28:24] and the table count in bits [20:16]; with the default parameters it reads 0x01010000. Index 5 reads the table width/32 in bits [19:16] and the table height/32 in bits [27:24]; with the default parameters it reads 0x04080000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| lut_we | output | 1 | Table write strobe |
| lut_x | output | CRD_W | Table slot column |
| lut_y | output | CRD_W | Table slot row |
| lut_sel | output | LUTID_W | Table id from the control word |
| lut_data | output | 32 | Physical address written into the slot |
| irq | output | 1 | Combined, masked interrupt |

## Verification
The assertions check the following on every cycle:
- Every table write lands inside the current rectangle.
- Each memory request lasts one cycle.
- Every first-word descriptor fetch is 16-byte aligned.
- Completion coincides with a table write.
- Once the error flag is set, the engine stops issuing reads and writes.
- The write-1-to-clear rule holds, and `irq` never rises without an enabled bit.
- Error and ready are never read together.

The bench scenarios show the behaviours that no cycle-level property can capture:
- The row-major order and exact count of entries.
- The walk across a two-descriptor chain.
- The abort after a partial fill.
- The three kinds of malformed descriptor.
- The contents of the identification registers.

// File: rtl/lut_refill_pkg.sv
package lut_refill_pkg;
  localparam int CRD_W  = 8;
  localparam int WORD_W = 32;

  typedef logic [CRD_W-1:0] crd_t;

  // rectangle word: x0 lowest byte, y1 highest
  typedef struct packed {
    crd_t y1;
    crd_t x1;
    crd_t y0;
    crd_t x0;
  } rect_t;

  typedef enum logic [2:0] {
    RA_DESC  = 3'd0,
    RA_STAT  = 3'd1,
    RA_ISTAT = 3'd2,
    RA_IEN   = 3'd3,
    RA_IDENT = 3'd4,
    RA_GEOM  = 3'd5
  } reg_idx_e;

  localparam int IRQ_DONE_BIT = 0;
  localparam int IRQ_ERR_BIT  = 1;

  typedef enum logic [1:0] {W_IDLE, W_DESC, W_CHECK, W_DATA} wstate_e;
endpackage

// File: rtl/lut_refill_raster.sv
module lut_refill_raster
  import lut_refill_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  input  crd_t x0,
  input  crd_t y0,
  input  crd_t x1,
  input  crd_t y1,
  output crd_t cur_x,
  output crd_t cur_y,
  output logic last
);
  crd_t bx0, bx1, by1;
  logic act;

  assign last = (cur_x == bx1) && (cur_y == by1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_x <= '0;
      cur_y <= '0;
      bx0   <= '0;
      bx1   <= '0;
      by1   <= '0;
      act   <= 1'b0;
    end else if (load) begin
      cur_x <= x0;
      cur_y <= y0;
      bx0   <= x0;
      bx1   <= x1;
      by1   <= y1;
      act   <= 1'b1;
    end else if (step) begin
      if (last) act <= 1'b0;
      if (cur_x == bx1) begin
        cur_x <= bx0;
        cur_y <= cur_y + 1'b1;
      end else begin
        cur_x <= cur_x + 1'b1;
      end
    end
  end

  // R2: the scan position never leaves the window
  p_in_window_r2: assert property (@(posedge clk) disable iff (rst)
    act |-> (cur_x >= bx0 && cur_x <= bx1 && cur_y <= by1));
endmodule

// File: rtl/lut_refill_walker.sv
module lut_refill_walker
  import lut_refill_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LUTID_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick,
  input  logic              abort,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              lut_we,
  output crd_t              lut_x,
  output crd_t              lut_y,
  output logic [LUTID_W-1:0] lut_sel,
  output logic [WORD_W-1:0] lut_data,
  output logic              busy,
  output logic              err_flag,
  output logic              done_evt,
  output logic              err_evt
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  wstate_e st;
  logic [ADDR_W-1:0] desc_q, nxt_q, dptr_q;
  rect_t rect_q;
  logic [LUTID_W-1:0] lut_q;
  logic [1:0] widx;
  logic pend, bad, r_load, r_step, r_last;
  crd_t rx, ry;

  assign bad    = (rect_q.x1 < rect_q.x0) || (rect_q.y1 < rect_q.y0) || (dptr_q[3:0] != 4'd0);
  assign r_load = (st == W_CHECK) && !bad && !kick && !abort;
  assign r_step = (st == W_DATA) && pend && mem_rvalid && !kick && !abort;
  assign busy   = (st != W_IDLE);

  lut_refill_raster u_raster (
    .clk(clk), .rst(rst), .load(r_load), .step(r_step),
    .x0(rect_q.x0), .y0(rect_q.y0), .x1(rect_q.x1), .y1(rect_q.y1),
    .cur_x(rx), .cur_y(ry), .last(r_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= W_IDLE;
      desc_q <= '0; nxt_q <= '0; dptr_q <= '0;
      rect_q <= '0; lut_q <= '0; widx <= '0; pend <= 1'b0;
      mem_req <= 1'b0; mem_addr <= '0;
      lut_we <= 1'b0; lut_x <= '0; lut_y <= '0; lut_sel <= '0; lut_data <= '0;
      err_flag <= 1'b0; done_evt <= 1'b0; err_evt <= 1'b0;
    end else begin
      mem_req  <= 1'b0;
      lut_we   <= 1'b0;
      done_evt <= 1'b0;
      err_evt  <= 1'b0;
      if (kick) begin
        pend     <= 1'b0;
        widx     <= '0;
        desc_q   <= start_addr;
        if (start_addr[3:0] != 4'd0) begin
          err_flag <= 1'b1;
          err_evt  <= 1'b1;
          st       <= W_IDLE;
        end else begin
          err_flag <= 1'b0;
          st       <= W_DESC;
        end
      end else if (abort) begin
        pend     <= 1'b0;
        err_flag <= 1'b0;
        st       <= W_IDLE;
      end else begin
        unique case (st)
          W_IDLE: ;
          W_DESC: begin
            if (!pend) begin
              mem_req  <= 1'b1;
              mem_addr <= desc_q + ADDR_W'({widx, 2'b00});
              pend     <= 1'b1;
            end else if (mem_rvalid) begin
              pend <= 1'b0;
              widx <= widx + 1'b1;
              unique case (widx)
                2'd0: nxt_q  <= mem_rdata[ADDR_W-1:0];
                2'd1: rect_q <= mem_rdata;
                2'd2: lut_q  <= mem_rdata[4 +: LUTID_W];
                default: begin
                  dptr_q <= mem_rdata[ADDR_W-1:0];
                  st     <= W_CHECK;
                end
              endcase
            end
          end
          W_CHECK: begin
            if (bad) begin
              err_flag <= 1'b1;
              err_evt  <= 1'b1;
              st       <= W_IDLE;
            end else begin
              st <= W_DATA;
            end
          end
          W_DATA: begin
            if (!pend) begin
              mem_req  <= 1'b1;
              mem_addr <= dptr_q;
              pend     <= 1'b1;
            end else if (mem_rvalid) begin
              pend     <= 1'b0;
              lut_we   <= 1'b1;
              lut_x    <= rx;
              lut_y    <= ry;
              lut_sel  <= lut_q;
              lut_data <= mem_rdata;
              dptr_q   <= dptr_q + STEP;
              if (r_last) begin
                if (nxt_q == '0) begin
                  done_evt <= 1'b1;
                  st       <= W_IDLE;
                end else if (nxt_q[3:0] != 4'd0) begin
                  err_flag <= 1'b1;
                  err_evt  <= 1'b1;
                  st       <= W_IDLE;
                end else begin
                  desc_q <= nxt_q;
                  widx   <= '0;
                  st     <= W_DESC;
                end
              end
            end
          end
          default: st <= W_IDLE;
        endcase
      end
    end
  end

  // R1: one outstanding read, one-cycle request
  p_req_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R1: first word of a descriptor is fetched from a 16-byte boundary
  p_desc_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    (mem_req && st == W_DESC && widx == 2'd0) |-> (mem_addr[3:0] == 4'd0));
  // R4: completion coincides with the final table write
  p_done_with_write_r4: assert property (@(posedge clk) disable iff (rst)
    done_evt |-> lut_we);
  // R5: a raised error halts all traffic
  p_err_halts_r5: assert property (@(posedge clk) disable iff (rst)
    (err_flag && $past(err_flag)) |-> (!lut_we && !mem_req));
endmodule

// File: rtl/lut_refill_regs.sv
module lut_refill_regs
  import lut_refill_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IRQ_W       = 8,
  parameter int NUM_ENGINES = 1,
  parameter int NUM_LUTS    = 1,
  parameter int LUT_COLS    = 256,
  parameter int LUT_ROWS    = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              kick,
  output logic              abort,
  output logic [ADDR_W-1:0] start_addr,
  input  logic              busy,
  input  logic              err_flag,
  input  logic              done_evt,
  input  logic              err_evt,
  output logic              irq
);
  localparam logic [WORD_W-1:0] IDENT_VAL =
    {3'b0, 5'(NUM_ENGINES), 3'b0, 5'(NUM_LUTS), 16'b0};
  localparam logic [WORD_W-1:0] GEOM_VAL =
    {4'b0, 4'(LUT_ROWS / 32), 4'b0, 4'(LUT_COLS / 32), 16'b0};

  logic [IRQ_W-1:0] istat, ien, iset, iclr;
  logic desc_wr;

  assign desc_wr    = reg_we && (reg_addr == 3'(RA_DESC));
  assign kick       = desc_wr && (reg_wdata != '0);
  assign abort      = desc_wr && (reg_wdata == '0);
  assign start_addr = reg_wdata[ADDR_W-1:0];

  always_comb begin
    iset = '0;
    iset[IRQ_DONE_BIT] = done_evt;
    iset[IRQ_ERR_BIT]  = err_evt;
    iclr = (reg_we && reg_addr == 3'(RA_ISTAT)) ? reg_wdata[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      istat     <= '0;
      ien       <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      istat <= (istat & ~iclr) | iset;
      if (reg_we && reg_addr == 3'(RA_IEN)) ien <= reg_wdata[IRQ_W-1:0];
      irq <= |(istat & ien);
      unique case (reg_addr)
        3'(RA_STAT):  reg_rdata <= {30'b0, err_flag, !busy && !err_flag};
        3'(RA_ISTAT): reg_rdata <= WORD_W'(istat);
        3'(RA_IEN):   reg_rdata <= WORD_W'(ien);
        3'(RA_IDENT): reg_rdata <= IDENT_VAL;
        3'(RA_GEOM):  reg_rdata <= GEOM_VAL;
        default:      reg_rdata <= '0;
      endcase
    end
  end

  // R6: a 1 written to the done bit clears it unless a new event lands
  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 3'(RA_ISTAT) && reg_wdata[IRQ_DONE_BIT] && !done_evt)
      |=> !istat[IRQ_DONE_BIT]);
  // R7: the line never rises without some enabled bit
  p_irq_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|ien));
  // R5: error and ready are never reported together
  p_err_over_ready_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 3'(RA_STAT)) |=> !(reg_rdata[0] && reg_rdata[1]));
endmodule

// File: rtl/lut_refill_engine.sv
module lut_refill_engine
  import lut_refill_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LUTID_W     = 4,
  parameter int IRQ_W       = 8,
  parameter int NUM_ENGINES = 1,
  parameter int NUM_LUTS    = 1,
  parameter int LUT_COLS    = 256,
  parameter int LUT_ROWS    = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  output logic               lut_we,
  output logic [CRD_W-1:0]   lut_x,
  output logic [CRD_W-1:0]   lut_y,
  output logic [LUTID_W-1:0] lut_sel,
  output logic [31:0]        lut_data,
  output logic               irq
);
  logic kick, abort, busy, err_flag, done_evt, err_evt;
  logic [ADDR_W-1:0] start_addr;

  lut_refill_regs #(
    .ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .NUM_ENGINES(NUM_ENGINES),
    .NUM_LUTS(NUM_LUTS), .LUT_COLS(LUT_COLS), .LUT_ROWS(LUT_ROWS)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .kick(kick), .abort(abort),
    .start_addr(start_addr), .busy(busy), .err_flag(err_flag),
    .done_evt(done_evt), .err_evt(err_evt), .irq(irq)
  );

  lut_refill_walker #(.ADDR_W(ADDR_W), .LUTID_W(LUTID_W)) u_walk (
    .clk(clk), .rst(rst), .kick(kick), .abort(abort), .start_addr(start_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .lut_we(lut_we), .lut_x(lut_x), .lut_y(lut_y),
    .lut_sel(lut_sel), .lut_data(lut_data), .busy(busy), .err_flag(err_flag),
    .done_evt(done_evt), .err_evt(err_evt)
  );
endmodule

// File: tb/lut_refill_engine_test.sv
`timescale 1ns/1ps
module lut_refill_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req;
  logic [31:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic lut_we;
  logic [7:0] lut_x, lut_y;
  logic [3:0] lut_sel;
  logic [31:0] lut_data;
  logic irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  logic [31:0] mem [0:255];
  logic [51:0] wlog [0:255];
  int wcnt = 0;

  always #5 clk = ~clk;

  lut_refill_engine uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .lut_we(lut_we), .lut_x(lut_x), .lut_y(lut_y), .lut_sel(lut_sel),
    .lut_data(lut_data), .irq(irq)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem[mem_addr[9:2]];
  end

  // table write recorder: {sel, y, x, data}
  always @(posedge clk) begin
    if (!rst && lut_we) begin
      wlog[wcnt[7:0]] <= {lut_sel, lut_y, lut_x, lut_data};
      wcnt <= wcnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !finished) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_end(output logic [31:0] s);
    s = '0;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, s);
      if (s[1:0] != 2'b00) break;
    end
    idle(4);
  endtask

  task automatic put_desc(input int a, input logic [31:0] nxt, input logic [31:0] rect,
                          input logic [31:0] ctrl, input logic [31:0] dp,
                          input int n, input logic [31:0] base);
    mem[a/4]     = nxt;
    mem[a/4 + 1] = rect;
    mem[a/4 + 2] = ctrl;
    mem[a/4 + 3] = dp;
    for (int i = 0; i < n; i++) mem[dp[9:2] + i] = base + i;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd1, v); check("R4 reset status", v, 64'h1);
    rd(3'd2, v); check("R6 reset istat", v, 64'h0);
    check("R7 reset irq", irq, 64'h0);
    check("R2 reset no writes", wcnt, 64'h0);
  endtask

  task automatic t_ident;
    logic [31:0] v;
    rd(3'd4, v); check("R8 ident", v, 64'h01010000);
    rd(3'd5, v); check("R8 geometry", v, 64'h04080000);
  endtask

  task automatic t_single;
    logic [31:0] s;
    int b;
    put_desc(32'h040, 32'h0, 32'h02040102, 32'h31, 32'h100, 6, 32'hA000);
    b = wcnt;
    wr(3'd0, 32'h040);
    wait_end(s);
    check("R4 ready after fill", s, 64'h1);
    check("R2 entry count", wcnt - b, 64'd6);
    for (int i = 0; i < 6; i++)
      check("R2 row-major entry", wlog[b + i],
            {12'b0, 4'd3, 8'(1 + i / 3), 8'(2 + i % 3), 32'hA000 + 32'(i)});
    rd(3'd2, s); check("R6 done latched", s, 64'h1);
  endtask

  task automatic t_irq;
    logic [31:0] s;
    idle(2);
    check("R7 masked irq low", irq, 64'h0);
    wr(3'd3, 32'h1); idle(2);
    check("R7 enabled irq high", irq, 64'h1);
    wr(3'd2, 32'h0); rd(3'd2, s);
    check("R6 write 0 keeps bit", s, 64'h1);
    wr(3'd2, 32'h1); rd(3'd2, s);
    check("R6 write 1 clears", s, 64'h0);
    idle(2);
    check("R7 irq falls", irq, 64'h0);
    wr(3'd3, 32'h0);
  endtask

  task automatic t_chain;
    logic [31:0] s;
    int b;
    put_desc(32'h080, 32'h0C0, 32'h0, 32'h50, 32'h200, 1, 32'hB000);
    put_desc(32'h0C0, 32'h0, 32'h07060705, 32'h21, 32'h240, 2, 32'hC000);
    b = wcnt;
    wr(3'd0, 32'h080);
    wait_end(s);
    check("R1 chain status", s, 64'h1);
    check("R1 chain count", wcnt - b, 64'd3);
    check("R1 chain first", wlog[b],     {12'b0, 4'd5, 8'd0, 8'd0, 32'hB000});
    check("R1 chain second", wlog[b + 1], {12'b0, 4'd2, 8'd7, 8'd5, 32'hC000});
    check("R1 chain third", wlog[b + 2],  {12'b0, 4'd2, 8'd7, 8'd6, 32'hC001});
    wr(3'd2, 32'hFF);
  endtask

  task automatic t_err_rect;
    logic [31:0] s;
    int b;
    put_desc(32'h300, 32'h0, 32'h00030005, 32'h10, 32'h340, 1, 32'hE000);
    b = wcnt;
    wr(3'd0, 32'h300);
    wait_end(s);
    check("R5 inverted rect status", s, 64'h2);
    check("R5 inverted rect writes", wcnt - b, 64'd0);
    rd(3'd2, s); check("R6 error latched", s, 64'h2);
    wr(3'd2, 32'hFF);
  endtask

  task automatic t_err_align;
    logic [31:0] s;
    int b;
    b = wcnt;
    wr(3'd0, 32'h044);
    wait_end(s);
    check("R5 misaligned start", s, 64'h2);
    check("R5 misaligned start writes", wcnt - b, 64'd0);
    put_desc(32'h380, 32'h3C4, 32'h09090909, 32'h10, 32'h3A0, 1, 32'hD000);
    b = wcnt;
    wr(3'd0, 32'h380);
    wait_end(s);
    check("R5 misaligned next status", s, 64'h2);
    check("R5 misaligned next writes", wcnt - b, 64'd1);
    put_desc(32'h2C0, 32'h0, 32'h0, 32'h10, 32'h3A4, 0, 32'h0);
    b = wcnt;
    wr(3'd0, 32'h2C0);
    wait_end(s);
    check("R5 misaligned data ptr", s, 64'h2);
    check("R5 misaligned data writes", wcnt - b, 64'd0);
  endtask

  task automatic t_abort;
    logic [31:0] s;
    int b, mid;
    put_desc(32'h2C0, 32'h0, 32'h07070000, 32'h10, 32'h000, 0, 32'h0);
    b = wcnt;
    wr(3'd0, 32'h2C0);
    rd(3'd1, s); check("R4 busy not ready", s, 64'h0);
    idle(30);
    wr(3'd0, 32'h0);
    idle(2);
    mid = wcnt;
    idle(60);
    check("R3 no writes after abort", wcnt, 64'(mid));
    check("R3 partial fill", (wcnt - b) < 64, 64'h1);
    rd(3'd1, s); check("R3 ready after abort", s, 64'h1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    idle(4);
    @(negedge clk) rst = 1'b0;
    t_reset;
    t_ident;
    t_single;
    t_irq;
    t_chain;
    t_err_rect;
    t_err_align;
    t_abort;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule